// File: doc/BRIEF.md
# Front-Panel Run/Deposit Controller

This block sits between a small processor and a hand-operated front panel. An operator uses twelve data switches and five debounced pushbuttons to do four things. The buttons load the program counter, step an address register forward, write words into memory and start or stop the processor. The controller drives a clock-enable for the processor, a one-cycle processor reset, a program-counter load strobe with its value, a memory write request, and two banks of twelve indicator lines. One bank shows an address and the other shows a data word.

The address register is the panel's view of the processor's program counter. While the machine is stopped, the panel owns the memory bus. It reads the word at the current address so that the data LEDs show it, and it writes switch values there on request. While the machine runs, the bus belongs to the processor. The address register then tracks the processor's program counter, so that stopping the machine leaves the panel pointing where execution stopped.

Every button acts once per press, on its rising edge. A held button is never repeated.

Top module: `fp_panel`

## Requirements
- R1: After `rst_n` is released, the machine is halted (`cpu_clk_en`=0, `bus_to_cpu`=0), the address register is 0, and `mem_we`, `pc_load` and `cpu_rst` are all low.
- R2: Each button produces exactly one action per press, on its rising edge; holding a button high for further cycles causes no further action.
- R3: A Reset press loads the address register from `sw`. In the cycle after the press, it raises `pc_load` with `pc_load_val` equal to `sw` and raises `cpu_rst`, each for exactly one cycle, and it leaves the machine halted.
- R4: A Run press while halted sets `cpu_clk_en` and `bus_to_cpu` from the cycle after the press; a Halt press clears them from the cycle after the press.
- R5: When Run and Halt rise in the same cycle, the machine ends up halted.
- R6: A Deposit press while halted raises `mem_we` for exactly one cycle, in the cycle after the press, with `mem_addr` equal to the address register and `mem_wdata` equal to `sw` at the press.
- R7: A Next press while halted adds one to the address register, wrapping from the all-ones address to 0. In the cycle after the press it raises `pc_load` for one cycle with `pc_load_val` equal to the new address.
- R8: Deposit and Next presses while running have no effect: no `mem_we`, no `pc_load`, and the address is unchanged.
- R9: While halted, `led_addr` shows the address register and `led_data` shows `mem_rdata`; while running, `led_addr` shows `cpu_pc` and `led_data` shows `cpu_bus`.
- R10: While running, the address register follows `cpu_pc`, so after a Halt press it holds the `cpu_pc` value present at the press.
- R11: Deposit and Next pressed together while halted write at the old address and then advance the address by one.
- R12: Reset pressed together with Run leaves the machine halted; Reset has the highest priority among the buttons.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 12 | Data switches |
| btn_reset | input | 1 | Reset button, debounced level |
| btn_halt | input | 1 | Halt button, debounced level |
| btn_run | input | 1 | Run button, debounced level |
| btn_deposit | input | 1 | Deposit button, debounced level |
| btn_next | input | 1 | Next button, debounced level |
| cpu_pc | input | 12 | Processor program counter |
| cpu_bus | input | 12 | Processor data bus value |
| mem_rdata | input | 12 | Memory read data at `mem_addr` |
| cpu_clk_en | output | 1 | Processor clock enable (high while running) |
| cpu_rst | output | 1 | One-cycle processor reset |
| bus_to_cpu | output | 1 | High while the processor owns the memory bus |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_load_val | output | 12 | Value to load into the program counter |
| mem_we | output | 1 | One-cycle memory write request |
| mem_addr | output | 12 | Panel memory address |
| mem_wdata | output | 12 | Panel memory write data |
| led_addr | output | 12 | Address indicator lines |
| led_data | output | 12 | Data indicator lines |

## Verification
Several properties are checked on every cycle:
- Button events never last two cycles.
- A halt event always leaves the machine stopped.
- Writes and load strobes are one cycle wide, and no write follows a cycle spent running.
- The load value always equals the address register.

The bench scenarios cover the rest:
- the exact switch values landing in the address register and on the write data;
- the wrap of the address from all ones to zero;
- which of the simultaneous-press orderings wins;
- the address captured from the processor at a halt;
- the LED source switching between memory and processor.

// File: rtl/fp_pkg.sv
package fp_pkg;
  // Button positions in the packed button vector; order is the priority
  // order used by the mode and address logic (higher index wins).
  localparam int BTN_N      = 5;
  localparam int BTN_NEXT   = 0;
  localparam int BTN_DEP    = 1;
  localparam int BTN_RUN    = 2;
  localparam int BTN_HALT   = 3;
  localparam int BTN_RESET  = 4;

  typedef enum logic {
    MODE_HALTED  = 1'b0,
    MODE_RUNNING = 1'b1
  } mode_t;
endpackage

// File: rtl/fp_edge.sv
module fp_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];

    // R2: one event per press, never two cycles in a row
    p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/fp_mode.sv
module fp_mode
  import fp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reset_ev,
  input  logic halt_ev,
  input  logic run_ev,
  output logic running,
  output logic cpu_rst
);
  mode_t mode_q, mode_d;
  logic  rst_pulse_q;

  always_comb begin
    mode_d = mode_q;
    if (reset_ev)     mode_d = MODE_HALTED;
    else if (halt_ev) mode_d = MODE_HALTED;
    else if (run_ev)  mode_d = MODE_RUNNING;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_HALTED;
      rst_pulse_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      rst_pulse_q <= reset_ev;
    end
  end

  assign running = (mode_q == MODE_RUNNING);
  assign cpu_rst = rst_pulse_q;

  // R5: a halt event always leaves the machine stopped, even with run
  p_halt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ev |=> !running);
  // R3 / R12: reset halts and pulses the processor reset
  p_reset_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_ev |=> (!running && cpu_rst));
  // R3: processor reset is a single-cycle pulse
  p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |=> !cpu_rst);
endmodule

// File: rtl/fp_addr.sv
module fp_addr #(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_ev,
  input  logic          dep_ev,
  input  logic          next_ev,
  input  logic          running,
  input  logic [DW-1:0] sw,
  input  logic [AW-1:0] cpu_pc,
  output logic [AW-1:0] addr,
  output logic          pc_load,
  output logic [AW-1:0] pc_load_val,
  output logic          mem_we,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  // Address step with natural wrap at the top of the address space.
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] addr_q;
  logic          load_q, we_q;
  logic [AW-1:0] load_val_q, wa_q;
  logic [DW-1:0] wd_q;
  logic          halted_dep, halted_next;

  assign halted_dep  = dep_ev  && !running && !reset_ev;
  assign halted_next = next_ev && !running && !reset_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
      we_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
    end else begin
      load_q <= 1'b0;
      we_q   <= 1'b0;
      if (reset_ev) begin
        addr_q     <= AW'(sw);
        load_q     <= 1'b1;
        load_val_q <= AW'(sw);
      end else if (running) begin
        addr_q <= cpu_pc;
      end else begin
        if (halted_dep) begin
          we_q <= 1'b1;
          wa_q <= addr_q;
          wd_q <= sw;
        end
        if (halted_next) begin
          addr_q     <= step_addr(addr_q);
          load_q     <= 1'b1;
          load_val_q <= step_addr(addr_q);
        end
      end
    end
  end

  assign addr        = addr_q;
  assign pc_load     = load_q;
  assign pc_load_val = load_val_q;
  assign mem_we      = we_q;
  assign wr_addr     = wa_q;
  assign wr_data     = wd_q;

  // R7: a load strobe always carries the panel's current address
  p_load_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_load_val == addr));
  // R6: write request lasts one cycle
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R7: load strobe lasts one cycle
  p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R8: a next event while running leaves no load strobe behind
  p_no_step_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (next_ev && running && !reset_ev) |=> !pc_load);
endmodule

// File: rtl/fp_panel.sv
module fp_panel
  import fp_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sw,
  input  logic          btn_reset,
  input  logic          btn_halt,
  input  logic          btn_run,
  input  logic          btn_deposit,
  input  logic          btn_next,
  input  logic [AW-1:0] cpu_pc,
  input  logic [DW-1:0] cpu_bus,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_clk_en,
  output logic          cpu_rst,
  output logic          bus_to_cpu,
  output logic          pc_load,
  output logic [AW-1:0] pc_load_val,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] led_addr,
  output logic [DW-1:0] led_data
);
  logic [BTN_N-1:0] btn_lvl, btn_ev;
  logic             reset_ev, halt_ev, run_ev, dep_ev, next_ev;
  logic             running;
  logic [AW-1:0]    addr, wr_addr;

  assign btn_lvl[BTN_RESET] = btn_reset;
  assign btn_lvl[BTN_HALT]  = btn_halt;
  assign btn_lvl[BTN_RUN]   = btn_run;
  assign btn_lvl[BTN_DEP]   = btn_deposit;
  assign btn_lvl[BTN_NEXT]  = btn_next;

  fp_edge #(.N(BTN_N)) u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .lvl (btn_lvl),
    .rise (btn_ev)
  );

  // Named events for the assertions
  assign reset_ev = btn_ev[BTN_RESET];
  assign halt_ev  = btn_ev[BTN_HALT];
  assign run_ev   = btn_ev[BTN_RUN];
  assign dep_ev   = btn_ev[BTN_DEP];
  assign next_ev  = btn_ev[BTN_NEXT];

  fp_mode u_mode (
    .clk (clk),
    .rst_n (rst_n),
    .reset_ev (reset_ev),
    .halt_ev (halt_ev),
    .run_ev (run_ev),
    .running (running),
    .cpu_rst (cpu_rst)
  );

  fp_addr #(.AW(AW), .DW(DW)) u_addr (
    .clk (clk),
    .rst_n (rst_n),
    .reset_ev (reset_ev),
    .dep_ev (dep_ev),
    .next_ev (next_ev),
    .running (running),
    .sw (sw),
    .cpu_pc (cpu_pc),
    .addr (addr),
    .pc_load (pc_load),
    .pc_load_val (pc_load_val),
    .mem_we (mem_we),
    .wr_addr (wr_addr),
    .wr_data (mem_wdata)
  );

  assign cpu_clk_en = running;
  assign bus_to_cpu = running;
  assign mem_addr   = mem_we ? wr_addr : addr;
  assign led_addr   = running ? cpu_pc : addr;
  assign led_data   = running ? cpu_bus : mem_rdata;

  // R8: no memory write follows a cycle spent running
  p_no_write_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(running));
  // R4: the machine only starts on a run event
  p_start_on_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !run_ev) |=> !running);
  // R9: the indicators never show the processor bus while halted
  p_led_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (led_data == mem_rdata));
endmodule

// File: tb/sim_fp_panel.sv
`timescale 1ns/1ps
module sim_fp_panel;
  localparam int AW = 12;
  localparam int DW = 12;
  localparam logic [AW-1:0] PC_VAL  = 12'h5A5;
  localparam logic [DW-1:0] BUS_VAL = 12'h3C3;
  localparam logic [DW-1:0] RD_KEY  = 12'hABC;
  localparam int NV = 12;
  // {btn[4:0] = reset,halt,run,deposit,next ; sw ; run ; addr ; we ; maddr ; load}
  localparam logic [43:0] VEC [NV] = '{
    {5'b10000, 12'h123, 1'b0, 12'h123, 1'b0, 12'h000, 1'b1}, // R3 reset
    {5'b00001, 12'h000, 1'b0, 12'h124, 1'b0, 12'h000, 1'b1}, // R7 next
    {5'b00010, 12'h777, 1'b0, 12'h124, 1'b1, 12'h124, 1'b0}, // R6 deposit
    {5'b00011, 12'h055, 1'b0, 12'h125, 1'b1, 12'h124, 1'b1}, // R11 both
    {5'b00100, 12'h000, 1'b1, 12'h5A5, 1'b0, 12'h000, 1'b0}, // R4 run
    {5'b00010, 12'h111, 1'b1, 12'h5A5, 1'b0, 12'h000, 1'b0}, // R8 deposit
    {5'b00001, 12'h000, 1'b1, 12'h5A5, 1'b0, 12'h000, 1'b0}, // R8 next
    {5'b01000, 12'h000, 1'b0, 12'h5A5, 1'b0, 12'h000, 1'b0}, // R10 halt
    {5'b01100, 12'h000, 1'b0, 12'h5A5, 1'b0, 12'h000, 1'b0}, // R5 run+halt
    {5'b10000, 12'hFFF, 1'b0, 12'hFFF, 1'b0, 12'h000, 1'b1}, // R3 reset
    {5'b00001, 12'h000, 1'b0, 12'h000, 1'b0, 12'h000, 1'b1}, // R7 wrap
    {5'b10100, 12'h010, 1'b0, 12'h010, 1'b0, 12'h000, 1'b1}  // R12 reset+run
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] sw = '0;
  logic [4:0] btn = '0;
  logic [AW-1:0] cpu_pc = PC_VAL;
  logic [DW-1:0] cpu_bus = BUS_VAL;
  logic [DW-1:0] mem_rdata;
  logic cpu_clk_en, cpu_rst, bus_to_cpu, pc_load, mem_we;
  logic [AW-1:0] pc_load_val, mem_addr, led_addr;
  logic [DW-1:0] mem_wdata, led_data;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign mem_rdata = mem_addr ^ RD_KEY;

  fp_panel #(.AW(AW), .DW(DW)) u0 (
    .clk (clk), .rst_n (rst_n), .sw (sw),
    .btn_reset (btn[4]), .btn_halt (btn[3]), .btn_run (btn[2]),
    .btn_deposit (btn[1]), .btn_next (btn[0]),
    .cpu_pc (cpu_pc), .cpu_bus (cpu_bus), .mem_rdata (mem_rdata),
    .cpu_clk_en (cpu_clk_en), .cpu_rst (cpu_rst), .bus_to_cpu (bus_to_cpu),
    .pc_load (pc_load), .pc_load_val (pc_load_val), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .led_addr (led_addr), .led_data (led_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", cpu_clk_en, 0);
    chk("R1 bus_to_cpu", bus_to_cpu, 0);
    chk("R1 addr", led_addr, 0);
    chk("R1 we/load/rst", {mem_we, pc_load, cpu_rst}, 0);
    chk("R1 led_data", led_data, RD_KEY);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      logic [AW-1:0] eaddr;
      v = VEC[i];
      sw  = v[38:27];
      btn = v[43:39];
      @(negedge clk);
      eaddr = v[25:14];
      chk($sformatf("R4 run v%0d", i), cpu_clk_en, v[26]);
      chk($sformatf("R9 led_addr v%0d", i), led_addr, eaddr);
      chk($sformatf("R6 we v%0d", i), mem_we, v[13]);
      chk($sformatf("R7 load v%0d", i), pc_load, v[0]);
      if (v[0])
        chk($sformatf("R7 load_val v%0d", i), pc_load_val, eaddr);
      if (v[13]) begin
        chk($sformatf("R6 maddr v%0d", i), mem_addr, v[12:1]);
        chk($sformatf("R6 wdata v%0d", i), mem_wdata, v[38:27]);
      end
      if (!v[26])
        chk($sformatf("R9 led_data v%0d", i), led_data,
            (v[13] ? v[12:1] : eaddr) ^ RD_KEY);
      else
        chk($sformatf("R9 led_data run v%0d", i), led_data, BUS_VAL);
      btn = '0;
      @(negedge clk);
      chk($sformatf("R6 we low v%0d", i), {mem_we, pc_load}, 0);
    end

    // R2: held Next steps only once (address is 0x010 here)
    btn = 5'b00001;
    @(negedge clk);
    chk("R2 first load", pc_load, 1);
    @(negedge clk);
    chk("R2 no repeat load", pc_load, 0);
    @(negedge clk);
    chk("R2 single step", led_addr, 12'h011);
    btn = '0;
    @(negedge clk);

    // R3: processor reset pulse is one cycle wide
    sw = 12'h200;
    btn = 5'b10000;
    @(negedge clk);
    chk("R3 cpu_rst high", cpu_rst, 1);
    chk("R3 load_val", pc_load_val, 12'h200);
    @(negedge clk);
    chk("R3 cpu_rst low", cpu_rst, 0);
    chk("R3 halted", cpu_clk_en, 0);
    btn = '0;
    @(negedge clk);

    // R4 / R10: run, processor moves, halt captures its counter
    btn = 5'b00100;
    @(negedge clk);
    chk("R4 bus_to_cpu", bus_to_cpu, 1);
    btn = '0;
    cpu_pc = 12'h0AB;
    @(negedge clk);
    chk("R9 led follows cpu_pc", led_addr, 12'h0AB);
    btn = 5'b01000;
    @(negedge clk);
    chk("R4 stopped", bus_to_cpu, 0);
    cpu_pc = 12'h0FF;
    @(negedge clk);
    chk("R10 captured pc", led_addr, 12'h0AB);
    btn = '0;
    @(negedge clk);

    finish_run();
  end
endmodule